// File: doc/BRIEF.md
# Virtual-Channel Input Controller

This block holds the control for one input virtual channel of a pipelined wormhole router. Flits arrive tagged as head, body, tail or single (head and tail in one flit) and are queued in a small buffer. A head flit reaching an idle channel starts a short sequence. The channel asks the route unit for an output port, then asks the VC allocator for a downstream virtual channel, and then sends flits through the crossbar one by one.

Each departure needs a switch grant and a downstream credit. The controller keeps a credit count for the downstream buffer that it loads from a parameter at reset. It returns one credit upstream for every flit that leaves its own buffer. When a tail flit leaves, the output VC is released. The channel then goes idle, or goes straight back to routing if the next packet's head is already waiting. The route unit and the allocators sit outside this block. Their results come in on single-cycle strobe inputs.

Top module: `vc_input_ctrl`

## Requirements
- R1: After reset the channel state is idle (state code 0). No request output is high, `overflow_o` is clear, and the credit count equals `CRED_DEPTH`.
- R2: A head-marked flit (kind bit 0 set: codes 01 head, 11 single) accepted while idle sets the state to routing (code 1) from the next cycle. In routing, `route_req_o` is high.
- R3: In routing, a `route_valid_i` strobe stores `route_port_i` and sets the state to waiting-for-VC (code 2) from the next cycle. `vca_req_o` is high in that state.
- R4: In waiting-for-VC, a `vca_grant_i` strobe stores `vca_ovc_i` and sets the state to active (code 3) from the next cycle.
- R5: `sw_req_o` is high only when three conditions hold together: the state is active, the buffer is not empty and the credit count is above zero. While it is high, `sw_port_o` and `sw_ovc_o` show the stored route and output VC, and `flit_kind_o` and `flit_data_o` show the oldest buffered flit.
- R6: `sw_grant_i` while `sw_req_o` is high removes the oldest flit. In that same cycle it raises `flit_valid_o` and `credit_o` and lowers the credit count by one. `credit_i` raises the count by one. A grant and a credit in the same cycle leave the count unchanged.
- R7: Body (00) and tail (10) flits never start route computation or VC allocation. All flits leave in arrival order.
- R8: When a tail-marked flit leaves (kind bit 1 set: codes 10, 11), `ovc_free_o` pulses in that cycle. The next state is routing if a flit remains in the buffer after that cycle, and idle otherwise.
- R9: A flit presented while the buffer holds `BUF_DEPTH` flits is discarded. From the next cycle `overflow_o` is high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_valid_i | input | 1 | Incoming flit strobe |
| flit_kind_i | input | 2 | Flit kind: 00 body, 01 head, 10 tail, 11 single |
| flit_data_i | input | DATA_W | Flit payload |
| route_req_o | output | 1 | Route computation request |
| route_valid_i | input | 1 | Route result strobe |
| route_port_i | input | PORT_W | Computed output port |
| vca_req_o | output | 1 | Output VC request |
| vca_grant_i | input | 1 | Output VC grant strobe |
| vca_ovc_i | input | OVC_W | Granted output VC |
| sw_req_o | output | 1 | Switch request |
| sw_grant_i | input | 1 | Switch grant |
| sw_port_o | output | PORT_W | Stored output port |
| sw_ovc_o | output | OVC_W | Stored output VC |
| flit_valid_o | output | 1 | Flit departs this cycle |
| flit_kind_o | output | 2 | Kind of oldest buffered flit |
| flit_data_o | output | DATA_W | Payload of oldest buffered flit |
| credit_i | input | 1 | Credit returned from downstream |
| credit_o | output | 1 | Credit sent upstream |
| ovc_free_o | output | 1 | Output VC released |
| state_o | output | 2 | Channel state code |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
Several results are combinational and appear in the cycle of the stimulus that causes them: switch request, flit outputs, `flit_valid_o`, `credit_o` and `ovc_free_o`. State changes and `overflow_o` come from registers and appear one cycle after the strobe. A credit given in one cycle can re-enable `sw_req_o` only from the next cycle. The bench applies inputs just after a rising edge and checks the combinational results a short settle time later, within that same cycle. It checks each registered consequence in the following cycle, after the next edge has updated it. The sweep runs packet lengths one through four, then covers credit exhaustion, back-to-back packets and buffer overflow.

// File: rtl/vc_ctrl_pkg.sv
package vc_ctrl_pkg;
  typedef enum logic [1:0] {
    KIND_BODY   = 2'b00,
    KIND_HEAD   = 2'b01,
    KIND_TAIL   = 2'b10,
    KIND_SINGLE = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    VC_IDLE    = 2'd0,
    VC_ROUTE   = 2'd1,
    VC_WAIT_VC = 2'd2,
    VC_ACTIVE  = 2'd3
  } vc_state_e;

  function automatic logic kind_is_head(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_is_tail(input logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/vc_flit_fifo.sv
module vc_flit_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;

  // R6
  fifo_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R9
  fifo_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
endmodule

// File: rtl/vc_credit_ctr.sv
module vc_credit_ctr #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic give_i,
  output logic avail_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_W'(DEPTH);
    else begin
      case ({take_i, give_i})
        2'b10:   cnt_q <= cnt_q - CNT_W'(1);
        2'b01:   cnt_q <= cnt_q + CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign avail_o = (cnt_q != '0);

  // R6
  cred_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R6
  cred_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> avail_o);
  // R6
  cred_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && give_i) |=> $stable(cnt_q));
endmodule

// File: rtl/vc_state_fsm.sv
module vc_state_fsm
  import vc_ctrl_pkg::*;
#(
  parameter int PORT_W = 3,
  parameter int OVC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_push_i,
  input  logic              route_valid_i,
  input  logic [PORT_W-1:0] route_i,
  input  logic              vca_grant_i,
  input  logic [OVC_W-1:0]  ovc_i,
  input  logic              tail_depart_i,
  input  logic              more_i,
  output vc_state_e         state_o,
  output logic [PORT_W-1:0] route_o,
  output logic [OVC_W-1:0]  ovc_o
);
  vc_state_e state_q, state_d;
  logic [PORT_W-1:0] route_q;
  logic [OVC_W-1:0]  ovc_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      VC_IDLE:    if (head_push_i)   state_d = VC_ROUTE;
      VC_ROUTE:   if (route_valid_i) state_d = VC_WAIT_VC;
      VC_WAIT_VC: if (vca_grant_i)   state_d = VC_ACTIVE;
      VC_ACTIVE:  if (tail_depart_i) state_d = more_i ? VC_ROUTE : VC_IDLE;
      default:                       state_d = VC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= VC_IDLE;
      route_q <= '0;
      ovc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == VC_ROUTE && route_valid_i) route_q <= route_i;
      if (state_q == VC_WAIT_VC && vca_grant_i) ovc_q <= ovc_i;
    end
  end

  assign state_o = state_q;
  assign route_o = route_q;
  assign ovc_o   = ovc_q;

  // R2
  head_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == VC_IDLE && head_push_i) |=> state_q == VC_ROUTE);
  // R3
  route_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == VC_ROUTE && route_valid_i) |=> (state_q == VC_WAIT_VC && route_q == $past(route_i)));
  // R4
  grant_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == VC_WAIT_VC && vca_grant_i) |=> (state_q == VC_ACTIVE && ovc_q == $past(ovc_i)));
  // R8
  tail_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_depart_i |=> (state_q == VC_IDLE || state_q == VC_ROUTE));
endmodule

// File: rtl/vc_input_ctrl.sv
module vc_input_ctrl
  import vc_ctrl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int BUF_DEPTH  = 4,
  parameter int CRED_DEPTH = 4,
  parameter int PORT_W     = 3,
  parameter int OVC_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flit_valid_i,
  input  logic [1:0]        flit_kind_i,
  input  logic [DATA_W-1:0] flit_data_i,
  output logic              route_req_o,
  input  logic              route_valid_i,
  input  logic [PORT_W-1:0] route_port_i,
  output logic              vca_req_o,
  input  logic              vca_grant_i,
  input  logic [OVC_W-1:0]  vca_ovc_i,
  output logic              sw_req_o,
  input  logic              sw_grant_i,
  output logic [PORT_W-1:0] sw_port_o,
  output logic [OVC_W-1:0]  sw_ovc_o,
  output logic              flit_valid_o,
  output logic [1:0]        flit_kind_o,
  output logic [DATA_W-1:0] flit_data_o,
  input  logic              credit_i,
  output logic              credit_o,
  output logic              ovc_free_o,
  output logic [1:0]        state_o,
  output logic              overflow_o
);
  localparam int ENTRY_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(BUF_DEPTH + 1);

  logic [ENTRY_W-1:0] front;
  logic               buf_empty, buf_full;
  logic [CNT_W-1:0]   buf_cnt;
  logic               accept, depart, tail_depart, more, cred_avail, ovf_q;
  vc_state_e          state;

  assign accept = flit_valid_i & ~buf_full;

  vc_flit_fifo #(.WIDTH(ENTRY_W), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .data_i  ({flit_kind_i, flit_data_i}),
    .pop_i   (depart),
    .data_o  (front),
    .empty_o (buf_empty),
    .full_o  (buf_full),
    .count_o (buf_cnt)
  );

  vc_credit_ctr #(.DEPTH(CRED_DEPTH)) u_cred (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (depart),
    .give_i  (credit_i),
    .avail_o (cred_avail)
  );

  assign flit_kind_o = front[ENTRY_W-1:DATA_W];
  assign flit_data_o = front[DATA_W-1:0];
  assign sw_req_o    = (state == VC_ACTIVE) & ~buf_empty & cred_avail;
  assign depart      = sw_req_o & sw_grant_i;
  assign tail_depart = depart & kind_is_tail(flit_kind_o);
  // a flit remains if more than one was stored or one lands this cycle
  assign more        = (buf_cnt > CNT_W'(1)) | accept;

  vc_state_fsm #(.PORT_W(PORT_W), .OVC_W(OVC_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .head_push_i   (accept & kind_is_head(flit_kind_i)),
    .route_valid_i (route_valid_i),
    .route_i       (route_port_i),
    .vca_grant_i   (vca_grant_i),
    .ovc_i         (vca_ovc_i),
    .tail_depart_i (tail_depart),
    .more_i        (more),
    .state_o       (state),
    .route_o       (sw_port_o),
    .ovc_o         (sw_ovc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovf_q <= 1'b0;
    else if (flit_valid_i & buf_full) ovf_q <= 1'b1;
  end

  assign route_req_o  = (state == VC_ROUTE);
  assign vca_req_o    = (state == VC_WAIT_VC);
  assign flit_valid_o = depart;
  assign credit_o     = depart;
  assign ovc_free_o   = tail_depart;
  assign state_o      = state;
  assign overflow_o   = ovf_q;

  // R9
  overflow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd3) |-> !flit_valid_o);
endmodule

// File: tb/vc_input_ctrl_tb.sv
module vc_input_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic flit_valid_i = 0; logic [1:0] flit_kind_i = 0; logic [DW-1:0] flit_data_i = 0;
  logic route_valid_i = 0; logic [2:0] route_port_i = 0;
  logic vca_grant_i = 0; logic [1:0] vca_ovc_i = 0;
  logic sw_grant_i = 0, credit_i = 0;
  logic route_req_o, vca_req_o, sw_req_o, flit_valid_o, credit_o, ovc_free_o, overflow_o;
  logic [2:0] sw_port_o; logic [1:0] sw_ovc_o, flit_kind_o, state_o;
  logic [DW-1:0] flit_data_o;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vc_input_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .flit_valid_i(flit_valid_i), .flit_kind_i(flit_kind_i), .flit_data_i(flit_data_i),
    .route_req_o(route_req_o), .route_valid_i(route_valid_i), .route_port_i(route_port_i),
    .vca_req_o(vca_req_o), .vca_grant_i(vca_grant_i), .vca_ovc_i(vca_ovc_i),
    .sw_req_o(sw_req_o), .sw_grant_i(sw_grant_i), .sw_port_o(sw_port_o), .sw_ovc_o(sw_ovc_o),
    .flit_valid_o(flit_valid_o), .flit_kind_o(flit_kind_o), .flit_data_o(flit_data_o),
    .credit_i(credit_i), .credit_o(credit_o), .ovc_free_o(ovc_free_o),
    .state_o(state_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    flit_valid_i = 0; route_valid_i = 0; vca_grant_i = 0; sw_grant_i = 0; credit_i = 0;
  endtask

  task automatic settle(); #2; endtask
  task automatic cyc(); @(posedge clk_i); #1; clr(); endtask

  task automatic push(input logic [1:0] k, input logic [DW-1:0] d);
    flit_valid_i = 1; flit_kind_i = k; flit_data_i = d;
  endtask

  task automatic give_credits(input int n);
    for (int i = 0; i < n; i++) begin
      credit_i = 1; settle(); cyc();
    end
  endtask

  // one packet of length len, routed to port len, output VC len-1
  task automatic run_packet(input int len);
    logic [1:0] k;
    for (int i = 0; i < len; i++) begin
      k = (len == 1) ? 2'b11 : (i == 0) ? 2'b01 : (i == len-1) ? 2'b10 : 2'b00;
      push(k, DW'(16'h100 * len + i)); settle();
      if (i == 0) chk("R2 idle before head", state_o, 0);
      else begin
        chk("R7 body keeps routing state", state_o, 1);
        chk("R2 route_req", route_req_o, 1);
      end
      cyc();
    end
    route_valid_i = 1; route_port_i = 3'(len); settle();
    chk("R2 routing state", state_o, 1);
    cyc();
    vca_grant_i = 1; vca_ovc_i = 2'(len - 1); settle();
    chk("R3 wait state", state_o, 2);
    chk("R3 vca_req", vca_req_o, 1);
    chk("R5 no sw_req before active", sw_req_o, 0);
    cyc();
    for (int i = 0; i < len; i++) begin
      k = (len == 1) ? 2'b11 : (i == 0) ? 2'b01 : (i == len-1) ? 2'b10 : 2'b00;
      sw_grant_i = 1; settle();
      chk("R4 active state", state_o, 3);
      chk("R5 sw_req", sw_req_o, 1);
      chk("R5 sw_port", sw_port_o, len);
      chk("R5 sw_ovc", sw_ovc_o, len - 1);
      chk("R7 kind order", flit_kind_o, k);
      chk("R7 data order", flit_data_o, 16'h100 * len + i);
      chk("R6 flit_valid", flit_valid_o, 1);
      chk("R6 credit_o", credit_o, 1);
      chk("R8 ovc_free", ovc_free_o, (i == len-1) ? 1 : 0);
      cyc();
    end
    settle();
    chk("R8 back to idle", state_o, 0);
    chk("R5 no sw_req idle", sw_req_o, 0);
    give_credits(len);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr();
    #(CLK_PERIOD * 2 + 1);
    rst_ni = 1;
    settle();
    // R1
    chk("R1 reset state", state_o, 0);
    chk("R1 reset route_req", route_req_o, 0);
    chk("R1 reset vca_req", vca_req_o, 0);
    chk("R1 reset sw_req", sw_req_o, 0);
    chk("R1 reset overflow", overflow_o, 0);
    cyc();

    for (int len = 1; len <= 4; len++) run_packet(len);

    // credit exhaustion: R6, also confirms R1 initial count of 4
    push(2'b01, 16'hA0); settle(); cyc();
    for (int i = 1; i < 4; i++) begin push(2'b00, DW'(16'hA0 + i)); settle(); cyc(); end
    route_valid_i = 1; route_port_i = 3'd2; settle(); cyc();
    vca_grant_i = 1; vca_ovc_i = 2'd1; settle(); cyc();
    for (int i = 0; i < 4; i++) begin
      sw_grant_i = 1; settle();
      chk("R1 initial credits allow send", sw_req_o, 1);
      chk("R7 data order credit test", flit_data_o, 16'hA0 + i);
      cyc();
    end
    push(2'b00, 16'hA4); settle(); cyc();
    push(2'b10, 16'hA5); settle();
    chk("R6 no credit no request", sw_req_o, 0);
    cyc();
    credit_i = 1; settle();
    chk("R6 credit effect next cycle", sw_req_o, 0);
    cyc();
    sw_grant_i = 1; credit_i = 1; settle();
    chk("R6 credit restores request", sw_req_o, 1);
    chk("R6 data A4", flit_data_o, 16'hA4);
    cyc();
    sw_grant_i = 1; settle();
    chk("R6 simultaneous grant and credit keep count", sw_req_o, 1);
    chk("R8 tail frees ovc", ovc_free_o, 1);
    cyc();
    settle();
    chk("R8 idle after credit test", state_o, 0);
    give_credits(4);

    // back-to-back: R8 tail to routing
    push(2'b11, 16'hB0); settle(); cyc();
    push(2'b01, 16'hB1); settle();
    chk("R7 head while routing stays", state_o, 1);
    cyc();
    push(2'b10, 16'hB2); route_valid_i = 1; route_port_i = 3'd5; settle(); cyc();
    vca_grant_i = 1; vca_ovc_i = 2'd1; settle(); cyc();
    sw_grant_i = 1; settle();
    chk("R5 single kind", flit_kind_o, 3);
    chk("R8 single frees ovc", ovc_free_o, 1);
    cyc(); settle();
    chk("R8 next head returns to routing", state_o, 1);
    chk("R8 route_req again", route_req_o, 1);
    chk("R5 no sw_req in routing", sw_req_o, 0);
    route_valid_i = 1; route_port_i = 3'd6; cyc();
    vca_grant_i = 1; vca_ovc_i = 2'd2; cyc();
    sw_grant_i = 1; settle();
    chk("R3 new port stored", sw_port_o, 6);
    chk("R4 new ovc stored", sw_ovc_o, 2);
    chk("R7 head B1", flit_data_o, 16'hB1);
    cyc();
    sw_grant_i = 1; settle();
    chk("R8 tail B2 frees", ovc_free_o, 1);
    cyc(); settle();
    chk("R8 idle after pair", state_o, 0);
    give_credits(3);

    // overflow: R9
    push(2'b01, 16'hC0); settle(); cyc();
    push(2'b00, 16'hC1); settle(); cyc();
    push(2'b00, 16'hC2); settle(); cyc();
    push(2'b10, 16'hC3); settle(); cyc();
    push(2'b00, 16'hCF); settle();
    chk("R9 flag not yet", overflow_o, 0);
    cyc(); settle();
    chk("R9 flag raised", overflow_o, 1);
    route_valid_i = 1; route_port_i = 3'd1; cyc();
    vca_grant_i = 1; vca_ovc_i = 2'd0; cyc();
    for (int i = 0; i < 4; i++) begin
      sw_grant_i = 1; settle();
      chk("R9 stored flits intact", flit_data_o, 16'hC0 + i);
      cyc();
    end
    settle();
    chk("R9 extra flit discarded", state_o, 0);
    chk("R9 buffer empty", sw_req_o, 0);
    chk("R9 flag sticky", overflow_o, 1);
    give_credits(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule